// File: doc/BRIEF.md
# Branch and Jump Target Unit

This unit works out where the program goes next for control-transfer instructions. Each cycle it takes a 32-bit instruction word, the address of that instruction, the value read from the register named in the instruction's test/link field, and the value read from its base-register field. One clock later it presents a taken flag and the next fetch address. It also presents a link-register write (index, data, enable) and a small code that classifies the transfer, for use by a return-address stack or fetch logic outside this unit.

Three families are decoded. PC-relative branches carry a 21-bit signed word displacement, counted from the instruction that follows. Conditional branches test the register against zero as a signed number, or test only its lowest bit. Register-indirect jumps share a single opcode, and a 2-bit hint field tells the call, return and plain-jump kinds apart. Every other opcode produces a not-taken result with the sequential address and no register write.

Top module: `branch_target_unit`

## Requirements
- R1: While reset is asserted, taken, next_pc, ret_wen, ret_widx, ret_wdata and flow_kind are all zero.
- R2: For opcodes 0x30, 0x34 and 0x38 to 0x3F (instr[31:26]), the taken target is pc + 4 + 4 × sign-extended instr[20:0].
- R3: Opcode 0x30 (unconditional branch) and opcode 0x34 (subroutine branch) are always taken, whatever the register value.
- R4: Signed tests against zero of ra_val: 0x39 taken when equal to zero, 0x3D when not zero, 0x3A when negative, 0x3B when at most zero, 0x3E when at least zero, 0x3F when positive.
- R5: Opcode 0x38 is taken when ra_val bit 0 is clear and opcode 0x3C when it is set. The other bits of ra_val have no effect.
- R6: Opcode 0x1A is always taken for every hint value, and its target is rb_val with bits 1:0 cleared.
- R7: For 0x30, 0x34 and 0x1A, ret_wen is 1 unless the link index instr[25:21] is 31. ret_widx equals instr[25:21] and ret_wdata equals pc + 4.
- R8: Conditional branches (0x38 to 0x3F) and all non-transfer opcodes leave ret_wen at 0.
- R9: When not taken, including for every opcode outside the transfer set, next_pc is pc + 4 and ret_wdata also shows pc + 4.
- R10: flow_kind encodes the transfer: 0 none, 1 conditional branch, 2 unconditional branch (0x30), 3 call (0x34, or 0x1A with hint instr[15:14]=1), 4 return (0x1A with hint 2), 5 plain indirect jump (0x1A with hint 0 or 3).
- R11: Every output reflects the inputs sampled at the preceding rising clock edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| ra_val | input | XLEN | Value of the register in instr[25:21] |
| rb_val | input | XLEN | Value of the register in instr[20:16] |
| taken | output | 1 | Control transfer taken |
| next_pc | output | XLEN | Next fetch address |
| ret_wen | output | 1 | Link register write enable |
| ret_widx | output | REG_W | Link register index |
| ret_wdata | output | XLEN | Link value (pc + 4) |
| flow_kind | output | 3 | Transfer classification |

## Verification
Two situations are hard to reach: the extreme displacements, where the sign bit of the 21-bit field decides whether the target moves backwards across an address wrap, and the opcode 0x1A kinds, where the hint bits overlap the displacement bits. The sweep covers all 64 opcodes against eight register values chosen at the signed boundaries (zero, ±1, the most positive and most negative values, and even/odd pairs), and all four hint values for each. Directed cases then set the largest forward and backward displacements at a pc near zero. The link index 31 recurs in the sweep so that write suppression is seen for every opcode.

// File: rtl/btu_pkg.sv
package btu_pkg;

   localparam int INSTR_W = 32;
   localparam int OP_W    = 6;

   localparam logic [OP_W-1:0] OPC_BRA  = 6'h30;
   localparam logic [OP_W-1:0] OPC_BCALL = 6'h34;
   localparam logic [OP_W-1:0] OPC_IND  = 6'h1A;
   localparam logic [2:0]      OPC_COND_HI = 3'b111;

   typedef enum logic [2:0] {
      FK_NONE = 3'd0,
      FK_COND = 3'd1,
      FK_UNC  = 3'd2,
      FK_CALL = 3'd3,
      FK_RET  = 3'd4,
      FK_IND  = 3'd5
   } flow_kind_e;

   typedef struct packed {
      logic       is_cond;
      logic       is_always;
      logic       is_ind;
      logic       links;
      logic [2:0] test_sel;
      flow_kind_e kind;
   } dec_t;

endpackage

// File: rtl/btu_decode.sv
module btu_decode
   import btu_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int DISP_W = 21
) (
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec,
   output logic [REG_W-1:0]   link_idx,
   output logic [DISP_W-1:0]  disp
);
   localparam int OP_LSB = INSTR_W - OP_W;

   logic [OP_W-1:0] op;
   logic [1:0]      hint;

   assign op       = instr[INSTR_W-1:OP_LSB];
   assign link_idx = instr[OP_LSB-1 -: REG_W];
   assign disp     = instr[DISP_W-1:0];
   assign hint     = instr[15:14];

   always_comb begin
      dec           = '0;
      dec.kind      = FK_NONE;
      dec.test_sel  = op[2:0];
      if (op[OP_W-1:3] == OPC_COND_HI) begin
         dec.is_cond = 1'b1;
         dec.kind    = FK_COND;
      end else if (op == OPC_BRA) begin
         dec.is_always = 1'b1;
         dec.links     = 1'b1;
         dec.kind      = FK_UNC;
      end else if (op == OPC_BCALL) begin
         dec.is_always = 1'b1;
         dec.links     = 1'b1;
         dec.kind      = FK_CALL;
      end else if (op == OPC_IND) begin
         dec.is_ind = 1'b1;
         dec.links  = 1'b1;
         unique case (hint)
            2'd1:    dec.kind = FK_CALL;
            2'd2:    dec.kind = FK_RET;
            default: dec.kind = FK_IND;
         endcase
      end
   end
endmodule

// File: rtl/btu_cond.sv
module btu_cond #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] val,
   input  logic [2:0]      sel,
   output logic            hit
);
   localparam int N_TEST = 8;

   logic neg, zero, low;
   logic [N_TEST-1:0] vec;

   assign neg  = val[XLEN-1];
   assign zero = (val == '0);
   assign low  = val[0];

   for (genvar k = 0; k < N_TEST; k++) begin : g_test
      if (k == 0)      begin : g_lbc assign vec[k] = ~low;          end
      else if (k == 1) begin : g_eq  assign vec[k] = zero;          end
      else if (k == 2) begin : g_lt  assign vec[k] = neg;           end
      else if (k == 3) begin : g_le  assign vec[k] = neg | zero;    end
      else if (k == 4) begin : g_lbs assign vec[k] = low;           end
      else if (k == 5) begin : g_ne  assign vec[k] = ~zero;         end
      else if (k == 6) begin : g_ge  assign vec[k] = ~neg;          end
      else             begin : g_gt  assign vec[k] = ~neg & ~zero;  end
   end

   assign hit = vec[sel];
endmodule

// File: rtl/btu_target.sv
module btu_target #(
   parameter int XLEN   = 64,
   parameter int DISP_W = 21
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   rb_val,
   output logic [XLEN-1:0]   seq_pc,
   output logic [XLEN-1:0]   rel_pc,
   output logic [XLEN-1:0]   ind_pc
);
   localparam int EXT_W = XLEN - DISP_W - 2;
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] offs;

   assign offs   = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
   assign seq_pc = pc + STEP;
   assign rel_pc = seq_pc + offs;
   assign ind_pc = {rb_val[XLEN-1:2], 2'b00};
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
   import btu_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int REG_W    = 5,
   parameter int DISP_W   = 21,
   parameter int ZERO_REG = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [INSTR_W-1:0]   instr,
   input  logic [XLEN-1:0]      pc,
   input  logic [XLEN-1:0]      ra_val,
   input  logic [XLEN-1:0]      rb_val,
   output logic                 taken,
   output logic [XLEN-1:0]      next_pc,
   output logic                 ret_wen,
   output logic [REG_W-1:0]     ret_widx,
   output logic [XLEN-1:0]      ret_wdata,
   output logic [2:0]           flow_kind
);
   localparam logic [REG_W-1:0] ZIDX = REG_W'(ZERO_REG);

   if (XLEN < DISP_W + 3) begin : g_bad_xlen
      $error("XLEN too narrow for displacement");
   end
   if (ZERO_REG >= (1 << REG_W)) begin : g_bad_zero
      $error("ZERO_REG out of index range");
   end
   if (REG_W + DISP_W + OP_W != INSTR_W) begin : g_bad_fmt
      $error("field widths do not fill the instruction");
   end

   dec_t              dec;
   logic [REG_W-1:0]  link_idx;
   logic [DISP_W-1:0] disp;
   logic              cond_hit;
   logic [XLEN-1:0]   seq_pc, rel_pc, ind_pc;

   btu_decode #(.REG_W(REG_W), .DISP_W(DISP_W)) u_dec (
      .instr(instr), .dec(dec), .link_idx(link_idx), .disp(disp)
   );

   btu_cond #(.XLEN(XLEN)) u_cond (
      .val(ra_val), .sel(dec.test_sel), .hit(cond_hit)
   );

   btu_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_tgt (
      .pc(pc), .disp(disp), .rb_val(rb_val),
      .seq_pc(seq_pc), .rel_pc(rel_pc), .ind_pc(ind_pc)
   );

   logic            take_d;
   logic [XLEN-1:0] npc_d;

   always_comb begin
      take_d = dec.is_always | dec.is_ind | (dec.is_cond & cond_hit);
      if (dec.is_ind)  npc_d = ind_pc;
      else if (take_d) npc_d = rel_pc;
      else             npc_d = seq_pc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken     <= 1'b0;
         next_pc   <= '0;
         ret_wen   <= 1'b0;
         ret_widx  <= '0;
         ret_wdata <= '0;
         flow_kind <= FK_NONE;
      end else begin
         taken     <= take_d;
         next_pc   <= npc_d;
         ret_wen   <= dec.links & (link_idx != ZIDX);
         ret_widx  <= link_idx;
         ret_wdata <= seq_pc;
         flow_kind <= dec.kind;
      end
   end
endmodule

// File: rtl/btu_chk.sv
module btu_chk #(
   parameter int XLEN     = 64,
   parameter int REG_W    = 5,
   parameter int ZERO_REG = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       instr,
   input logic [XLEN-1:0]   pc,
   input logic [XLEN-1:0]   ra_val,
   input logic [XLEN-1:0]   rb_val,
   input logic              taken,
   input logic [XLEN-1:0]   next_pc,
   input logic              ret_wen,
   input logic [REG_W-1:0]  ret_widx,
   input logic [XLEN-1:0]   ret_wdata,
   input logic [2:0]        flow_kind
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R7
   zero_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_wen |-> ret_widx != REG_W'(ZERO_REG));

   // R10
   none_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_kind == 3'd0 |-> !taken);

   // R3
   uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(instr[31:26]) == 6'h30 || $past(instr[31:26]) == 6'h34) |-> taken);

   // R8
   cond_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(instr[31:29]) == 3'b111 |-> !ret_wen);

   // R4
   eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      ($past(instr[31:26]) == 6'h39 && $past(ra_val) == '0) |-> taken);

   // R6
   ind_target_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(instr[31:26]) == 6'h1A |-> (taken && next_pc == ($past(rb_val) & ~XLEN'(3))));

   // R9
   seq_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      !taken |-> (next_pc == $past(pc) + XLEN'(4) && ret_wdata == next_pc));
endmodule

bind branch_target_unit btu_chk #(.XLEN(XLEN), .REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .ra_val(ra_val),
   .rb_val(rb_val), .taken(taken), .next_pc(next_pc), .ret_wen(ret_wen),
   .ret_widx(ret_widx), .ret_wdata(ret_wdata), .flow_kind(flow_kind)
);

// File: tb/tb_branch_target_unit.sv
`timescale 1ns/1ps
module tb_branch_target_unit;
   localparam int XLEN = 64;
   localparam int REG_W = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] pc = '0, ra_val = '0, rb_val = '0;
   logic            taken, ret_wen;
   logic [XLEN-1:0] next_pc, ret_wdata;
   logic [REG_W-1:0] ret_widx;
   logic [2:0]      flow_kind;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   branch_target_unit dut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .ra_val(ra_val),
      .rb_val(rb_val), .taken(taken), .next_pc(next_pc), .ret_wen(ret_wen),
      .ret_widx(ret_widx), .ret_wdata(ret_wdata), .flow_kind(flow_kind)
   );

   task automatic chk(input string req, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s op=%h actual=%h expected=%h", req, what,
                  instr[31:26], act, exp);
      end
   endtask

   task automatic run_one(input logic [31:0] iw, input logic [XLEN-1:0] p,
                          input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
      logic [5:0] op;
      logic [XLEN-1:0] seq, rel, e_pc;
      logic e_take, e_wen, links;
      logic [2:0] e_kind;
      longint sa;
      string rt;
      @(negedge clk);
      instr = iw; pc = p; ra_val = a; rb_val = b;
      op  = iw[31:26];
      sa  = longint'(a);
      seq = p + 64'd4;
      rel = seq + (XLEN'(longint'($signed(iw[20:0]))) << 2);
      e_take = 1'b0; links = 1'b0; e_kind = 3'd0; rt = "R9";
      case (op)
         6'h30: begin e_take = 1; links = 1; e_kind = 3'd2; rt = "R3"; end
         6'h34: begin e_take = 1; links = 1; e_kind = 3'd3; rt = "R3"; end
         6'h38: begin e_take = (a[0] == 1'b0); e_kind = 3'd1; rt = "R5"; end
         6'h3C: begin e_take = (a[0] == 1'b1); e_kind = 3'd1; rt = "R5"; end
         6'h39: begin e_take = (sa == 0); e_kind = 3'd1; rt = "R4"; end
         6'h3D: begin e_take = (sa != 0); e_kind = 3'd1; rt = "R4"; end
         6'h3A: begin e_take = (sa < 0);  e_kind = 3'd1; rt = "R4"; end
         6'h3B: begin e_take = (sa <= 0); e_kind = 3'd1; rt = "R4"; end
         6'h3E: begin e_take = (sa >= 0); e_kind = 3'd1; rt = "R4"; end
         6'h3F: begin e_take = (sa > 0);  e_kind = 3'd1; rt = "R4"; end
         6'h1A: begin
            e_take = 1; links = 1; rt = "R6";
            e_kind = (iw[15:14] == 2'd1) ? 3'd3 : (iw[15:14] == 2'd2) ? 3'd4 : 3'd5;
         end
         default: ;
      endcase
      if (op == 6'h1A)   e_pc = {b[XLEN-1:2], 2'b00};
      else if (e_take)   e_pc = rel;
      else               e_pc = seq;
      e_wen = links && (iw[25:21] != 5'd31);
      @(negedge clk);
      chk(rt, "taken", XLEN'(taken), XLEN'(e_take));
      if (!e_take)           chk("R9", "next_pc", next_pc, e_pc);
      else if (op == 6'h1A)  chk("R6", "next_pc", next_pc, e_pc);
      else                   chk("R2", "next_pc", next_pc, e_pc);
      chk(links ? "R7" : "R8", "ret_wen", XLEN'(ret_wen), XLEN'(e_wen));
      chk("R7", "ret_wdata", ret_wdata, seq);
      if (links) chk("R7", "ret_widx", XLEN'(ret_widx), XLEN'(iw[25:21]));
      chk("R10", "flow_kind", XLEN'(flow_kind), XLEN'(e_kind));
   endtask

   initial begin
      logic [XLEN-1:0] vals [8];
      vals[0] = 64'd0;                 vals[1] = 64'd1;
      vals[2] = 64'hFFFF_FFFF_FFFF_FFFF; vals[3] = 64'd2;
      vals[4] = 64'hFFFF_FFFF_FFFF_FFFE; vals[5] = 64'h7FFF_FFFF_FFFF_FFFF;
      vals[6] = 64'h8000_0000_0000_0000; vals[7] = 64'h0000_0001_0000_0000;

      // R1: reset holds all outputs at zero, even with a taken branch at the inputs
      instr = {6'h30, 5'd3, 21'h000010}; pc = 64'h1000; rb_val = 64'h77;
      repeat (3) @(negedge clk);
      chk("R1", "taken", XLEN'(taken), '0);
      chk("R1", "next_pc", next_pc, '0);
      chk("R1", "ret_wen", XLEN'(ret_wen), '0);
      chk("R1", "ret_widx", XLEN'(ret_widx), '0);
      chk("R1", "ret_wdata", ret_wdata, '0);
      chk("R1", "flow_kind", XLEN'(flow_kind), '0);
      rst_n = 1'b1;

      // R11: sweep; each result is sampled one edge after its inputs
      for (int op = 0; op < 64; op++) begin
         for (int v = 0; v < 8; v++) begin
            for (int h = 0; h < 4; h++) begin
               logic [20:0] rest;
               logic [4:0]  ri;
               rest = 21'($urandom);
               rest[15:14] = 2'(h);
               ri = (v == 3 || h == 2) ? 5'd31 : 5'(v * 4 + h);
               run_one({6'(op), ri, rest}, {$urandom, $urandom} & ~64'd3,
                       vals[v], {$urandom, $urandom});
            end
         end
      end

      // R2: extreme displacements around a pc near zero (backward wraps)
      run_one({6'h30, 5'd1, 21'h0FFFFF}, 64'h8, '0, '0);
      run_one({6'h30, 5'd1, 21'h100000}, 64'h8, '0, '0);
      run_one({6'h34, 5'd26, 21'h1FFFFF}, 64'h0, '0, '0);
      run_one({6'h3F, 5'd2, 21'h100000}, 64'hFFFF_FFFF_FFFF_FFFC, 64'd5, '0);
      // R5: high bits set but bit 0 clear
      run_one({6'h38, 5'd4, 21'h000003}, 64'h400, 64'hFFFF_FFFF_FFFF_FFF0, '0);
      run_one({6'h3C, 5'd4, 21'h000003}, 64'h400, 64'hFFFF_FFFF_FFFF_FFF0, '0);
      // R6: unaligned base register
      run_one({6'h1A, 5'd26, 5'd27, 2'd2, 14'h0}, 64'h2000, '0, 64'h1234_5677);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule